// File: doc/BRIEF.md
# ECG Command Sequencer

This block sits between a host byte stream and a byte-level SPI master wired to a multichannel biopotential ADC. The host writes packet bytes through a Wishbone-style write port into a shared command FIFO. The sequencer inspects the head of the FIFO and waits until a complete packet is present. It then runs one of four flows: a single-byte command, a register read burst, a register write burst, or a continuous sample stream. Bytes received over SPI during read flows are returned on a one-cycle result strobe.

While a packet is running, the stall output stays high, so the host holds its next request. The one exception is the data phase of a stream. During that phase the port stays open so that a stop byte can arrive. A byte that is not a known opcode is discarded and reported with an error pulse.

Top module: `ecg_seq_ctrl`

## Requirements
- R1: A write is accepted in a cycle where `wb_cyc_i`, `wb_stb_i` are high and `wb_stall_o` is low. `wb_ack_o` is high in the following cycle. Stall is high whenever the FIFO holds DEPTH bytes, so exactly DEPTH bytes are taken before stall rises if nothing is drained.
- R2: The opcodes 0x02 (wake), 0x04 (standby), 0x06 (reset) and 0x11 (stop, when idle) each produce exactly one SPI byte equal to the opcode. They produce no result bytes.
- R3: A register read is opcode 0x20..0x3F (start address in bits 4:0) followed by a byte n. The SPI sends the opcode, then n, then n+1 bytes of 0x00. The byte received for each of those n+1 transfers is returned on the result port, in order.
- R4: A register write is opcode 0x40..0x5F followed by n and n+1 data bytes. The SPI sends the opcode, n and the data bytes, in FIFO order, and no result is produced. No SPI activity for the packet begins until all n+3 bytes are in the FIFO.
- R5: A stream is opcode 0x10 followed by a frame count k ≥ 1. The SPI sends 0x10, then k·FRAME_BYTES bytes of 0x00. Every received byte is returned, and the transaction then ends.
- R6: A stream with k = 0 runs until a 0x11 byte is at the FIFO head at a frame boundary. That byte is consumed without being sent. The result count is then a whole number of frames, and the next packet executes normally.
- R7: Stall is high while any packet is executing, except during the data phase of a stream, where it follows only the FIFO level.
- R8: Any other opcode (for example 0x77, 0x80..0xFF) is removed from the FIFO and raises `err_o` for one cycle. It causes no SPI activity, and the packet behind it executes normally.
- R9: Chip select is low for the whole of a packet's SPI transfers. Every transfer is started while it is low. It returns high for at least one cycle between consecutive packets.
- R10: After reset, stall, go, result valid and error are low and chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wb_cyc_i | input | 1 | Bus cycle active |
| wb_stb_i | input | 1 | Write strobe |
| wb_dat_i | input | 8 | Packet byte from host |
| wb_stall_o | output | 1 | Hold off new writes |
| wb_ack_o | output | 1 | Write acknowledged (one cycle after acceptance) |
| spi_go_o | output | 1 | One-cycle request to shift a byte |
| spi_tx_o | output | 8 | Byte to shift out, valid with go |
| spi_done_i | input | 1 | SPI master finished the byte |
| spi_rx_i | input | 8 | Byte shifted in, valid with done |
| spi_cs_n_o | output | 1 | ADC chip select, active low |
| res_valid_o | output | 1 | Result byte strobe |
| res_data_o | output | 8 | Result byte |
| err_o | output | 1 | Unknown opcode pulse |

## Verification
Acknowledge is due one cycle after the accepting edge. A result strobe is due one cycle after the edge on which `spi_done_i` is seen. The error pulse follows the cycle in which the bad opcode leaves the FIFO. A new go can appear combinationally in the cycle after a done. The bench therefore drives and samples only on falling edges, where every registered output already shows the value from the preceding rising edge. The SPI model logs each go, together with chip select and stall, in the same falling-edge pass in which it handles its own done timing. Packets are then compared only after thirty quiet cycles, so the results do not depend on the random SPI latency.

// File: rtl/ecg_seq_pkg.sv
package ecg_seq_pkg;
   localparam logic [7:0] OP_WAKE   = 8'h02;
   localparam logic [7:0] OP_STBY   = 8'h04;
   localparam logic [7:0] OP_RESET  = 8'h06;
   localparam logic [7:0] OP_STREAM = 8'h10;
   localparam logic [7:0] OP_STOP   = 8'h11;
   localparam logic [2:0] RREG_PFX  = 3'b001;
   localparam logic [2:0] WREG_PFX  = 3'b010;

   typedef enum logic [1:0] {K_ONE, K_STREAM, K_RREG, K_WREG} kind_t;
   typedef enum logic [1:0] {ST_IDLE, ST_OP, ST_ARG, ST_DATA} st_t;

   typedef struct packed {
      logic  known;
      kind_t kind;
   } op_cls_t;

   function automatic op_cls_t op_class(input logic [7:0] b);
      op_cls_t c;
      c.known = 1'b1;
      c.kind  = K_ONE;
      if (b == OP_WAKE || b == OP_STBY || b == OP_RESET || b == OP_STOP)
         c.kind = K_ONE;
      else if (b == OP_STREAM)
         c.kind = K_STREAM;
      else if (b[7:5] == RREG_PFX)
         c.kind = K_RREG;
      else if (b[7:5] == WREG_PFX)
         c.kind = K_WREG;
      else
         c.known = 1'b0;
      return c;
   endfunction
endpackage

// File: rtl/ecg_cmd_fifo.sv
module ecg_cmd_fifo #(
   parameter int DEPTH = 512,
   parameter int W     = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       push,
   input  logic [W-1:0]               din,
   input  logic                       pop,
   output logic [W-1:0]               head0,
   output logic [W-1:0]               head1,
   output logic [$clog2(DEPTH):0]     count,
   output logic                       full
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = AW + 1;

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] rd_ptr, wr_ptr;

   assign head0 = mem[rd_ptr];
   assign head1 = mem[rd_ptr + AW'(1)];
   assign full  = (count == CW'(DEPTH));

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr + AW'(1);
         if (pop)  rd_ptr <= rd_ptr + AW'(1);
         case ({push, pop})
            2'b10:   count <= count + CW'(1);
            2'b01:   count <= count - CW'(1);
            default: count <= count;
         endcase
      end
   end

   a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (count < CW'(DEPTH)));
   a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> (count != '0));
endmodule

// File: rtl/ecg_seq_fsm.sv
module ecg_seq_fsm
   import ecg_seq_pkg::*;
#(
   parameter int CW          = 10,
   parameter int FRAME_BYTES = 27
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] fifo_count,
   input  logic [7:0]    head0,
   input  logic [7:0]    head1,
   output logic          fifo_pop,
   output logic          spi_go,
   output logic [7:0]    spi_tx,
   input  logic          spi_done,
   input  logic [7:0]    spi_rxd,
   output logic          spi_cs_n,
   output logic          res_valid,
   output logic [7:0]    res_data,
   output logic          err,
   output logic          hold
);
   localparam int FBW = $clog2(FRAME_BYTES) + 1;

   st_t          st;
   kind_t        kind;
   logic         issued;
   logic [7:0]   op, arg, frames_left;
   logic         unlimited;
   logic [8:0]   left;
   logic [FBW-1:0] fbyte;

   op_cls_t      cls;
   logic         have, ready, finish, frame_end, stop_seen, stream_data;
   logic [9:0]   need;

   always_comb begin
      cls   = op_class(head0);
      have  = (fifo_count != '0);
      case (cls.kind)
         K_ONE:   need = 10'd1;
         K_WREG:  need = 10'd3 + {2'b00, head1};
         default: need = 10'd2;
      endcase
      ready = have && cls.known && (int'(fifo_count) >= int'(need))
              && (cls.kind != K_WREG || int'(fifo_count) >= 2);
      finish      = issued && spi_done;
      frame_end   = (fbyte == FBW'(FRAME_BYTES - 1));
      stop_seen   = have && (head0 == OP_STOP);
      stream_data = (st == ST_DATA) && (kind == K_STREAM);
   end

   assign spi_cs_n = (st == ST_IDLE);
   assign spi_go   = (st != ST_IDLE) && !issued;
   assign hold     = (st != ST_IDLE) && !stream_data;

   always_comb begin
      case (st)
         ST_OP:   spi_tx = op;
         ST_ARG:  spi_tx = arg;
         ST_DATA: spi_tx = (kind == K_WREG) ? head0 : 8'h00;
         default: spi_tx = 8'h00;
      endcase
   end

   always_comb begin
      fifo_pop = 1'b0;
      case (st)
         ST_IDLE: fifo_pop = have && (!cls.known || ready);
         ST_OP:   fifo_pop = finish && (kind != K_ONE);
         ST_DATA: fifo_pop = (spi_go && kind == K_WREG)
                          || (finish && kind == K_STREAM && frame_end && stop_seen);
         default: fifo_pop = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st          <= ST_IDLE;
         kind        <= K_ONE;
         issued      <= 1'b0;
         op          <= '0;
         arg         <= '0;
         frames_left <= '0;
         unlimited   <= 1'b0;
         left        <= '0;
         fbyte       <= '0;
         res_valid   <= 1'b0;
         res_data    <= '0;
         err         <= 1'b0;
      end else begin
         res_valid <= 1'b0;
         err       <= 1'b0;
         if (spi_go) issued <= 1'b1;
         if (finish) issued <= 1'b0;
         case (st)
            ST_IDLE: begin
               if (have && !cls.known) begin
                  err <= 1'b1;
               end else if (ready) begin
                  st   <= ST_OP;
                  op   <= head0;
                  kind <= cls.kind;
                  arg  <= head1;
               end
            end
            ST_OP: if (finish) begin
               case (kind)
                  K_ONE: st <= ST_IDLE;
                  K_STREAM: begin
                     st          <= ST_DATA;
                     frames_left <= arg;
                     unlimited   <= (arg == 8'd0);
                     fbyte       <= '0;
                  end
                  default: st <= ST_ARG;
               endcase
            end
            ST_ARG: if (finish) begin
               st   <= ST_DATA;
               left <= {1'b0, arg} + 9'd1;
            end
            ST_DATA: if (finish) begin
               if (kind != K_WREG) begin
                  res_valid <= 1'b1;
                  res_data  <= spi_rxd;
               end
               if (kind == K_STREAM) begin
                  if (frame_end) begin
                     fbyte <= '0;
                     if (!unlimited) frames_left <= frames_left - 8'd1;
                     if ((!unlimited && frames_left == 8'd1) || stop_seen)
                        st <= ST_IDLE;
                  end else begin
                     fbyte <= fbyte + FBW'(1);
                  end
               end else begin
                  left <= left - 9'd1;
                  if (left == 9'd1) st <= ST_IDLE;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   a_r2_go_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      spi_go |=> !spi_go);
   a_r3_result_after_done: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> $past(spi_done));
   a_r8_err_without_spi: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (spi_cs_n && !spi_go));
endmodule

// File: rtl/ecg_seq_ctrl.sv
module ecg_seq_ctrl #(
   parameter int DEPTH       = 512,
   parameter int FRAME_BYTES = 27
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wb_cyc_i,
   input  logic       wb_stb_i,
   input  logic [7:0] wb_dat_i,
   output logic       wb_stall_o,
   output logic       wb_ack_o,
   output logic       spi_go_o,
   output logic [7:0] spi_tx_o,
   input  logic       spi_done_i,
   input  logic [7:0] spi_rx_i,
   output logic       spi_cs_n_o,
   output logic       res_valid_o,
   output logic [7:0] res_data_o,
   output logic       err_o
);
   localparam int CW = $clog2(DEPTH) + 1;

   generate
      if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("DEPTH must be a power of two of at least 4");
      end
      if (FRAME_BYTES < 1 || FRAME_BYTES > 255) begin : g_bad_frame
         $error("FRAME_BYTES must lie in 1..255");
      end
   endgenerate

   logic          accept, pop, full, hold;
   logic [7:0]    head0, head1;
   logic [CW-1:0] count;

   assign wb_stall_o = full || hold;
   assign accept     = wb_cyc_i && wb_stb_i && !wb_stall_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wb_ack_o <= 1'b0;
      else        wb_ack_o <= accept;
   end

   ecg_cmd_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(accept), .din(wb_dat_i), .pop(pop),
      .head0(head0), .head1(head1), .count(count), .full(full)
   );

   ecg_seq_fsm #(.CW(CW), .FRAME_BYTES(FRAME_BYTES)) u_fsm (
      .clk(clk), .rst_n(rst_n), .fifo_count(count), .head0(head0), .head1(head1),
      .fifo_pop(pop), .spi_go(spi_go_o), .spi_tx(spi_tx_o), .spi_done(spi_done_i),
      .spi_rxd(spi_rx_i), .spi_cs_n(spi_cs_n_o), .res_valid(res_valid_o),
      .res_data(res_data_o), .err(err_o), .hold(hold)
   );

   a_r9_go_under_cs: assert property (@(posedge clk) disable iff (!rst_n)
      spi_go_o |-> !spi_cs_n_o);
   a_r7_no_ack_without_req: assert property (@(posedge clk) disable iff (!rst_n)
      wb_ack_o |-> $past(wb_stb_i));
endmodule

// File: tb/ecg_seq_ctrl_tb.sv
module ecg_seq_ctrl_tb;
   localparam int DEPTH = 16;
   localparam int FB    = 4;

   logic clk = 1'b0, rst_n = 1'b0;
   logic wb_cyc = 1'b0, wb_stb = 1'b0;
   logic [7:0] wb_dat = '0;
   logic wb_stall, wb_ack, spi_go, spi_done = 1'b0, spi_cs_n, res_valid, err;
   logic [7:0] spi_tx, spi_rx = '0, res_data;

   always #10 clk = ~clk;

   ecg_seq_ctrl #(.DEPTH(DEPTH), .FRAME_BYTES(FB)) u_dut (
      .clk(clk), .rst_n(rst_n), .wb_cyc_i(wb_cyc), .wb_stb_i(wb_stb), .wb_dat_i(wb_dat),
      .wb_stall_o(wb_stall), .wb_ack_o(wb_ack), .spi_go_o(spi_go), .spi_tx_o(spi_tx),
      .spi_done_i(spi_done), .spi_rx_i(spi_rx), .spi_cs_n_o(spi_cs_n),
      .res_valid_o(res_valid), .res_data_o(res_data), .err_o(err)
   );

   int checks = 0, fails = 0;
   int lat = 2, err_seen = 0, cs_falls = 0;
   bit cur_stream = 0, chk_stall = 1, finished = 0;
   logic [7:0] got_tx[$], got_res[$], exp_tx[$], exp_res[$];

   function automatic logic [7:0] rxv(input int i);
      return 8'(i * 37 + 11) ^ 8'hC3;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // SPI slave model and monitor, all on falling edges
   initial begin
      int cd = 0, idx = 0, cur = 0;
      bit sbusy = 0, prev_cs = 1;
      forever begin
         @(negedge clk);
         spi_done = 1'b0;
         if (!rst_n) begin
            sbusy = 0; idx = 0;
         end else begin
            if (res_valid) got_res.push_back(res_data);
            if (err) err_seen++;
            if (prev_cs && !spi_cs_n) cs_falls++;
            prev_cs = spi_cs_n;
            if (spi_cs_n) idx = 0;
            if (spi_go) begin
               got_tx.push_back(spi_tx);
               chk(!spi_cs_n, "R9", int'(spi_cs_n), 0);
               if (chk_stall) begin
                  if (cur_stream && idx >= 1) chk(!wb_stall, "R7", int'(wb_stall), 0);
                  else                        chk(wb_stall, "R7", int'(wb_stall), 1);
               end
               cd = lat; sbusy = 1; cur = idx; idx++;
            end else if (sbusy) begin
               cd--;
               if (cd == 0) begin
                  spi_done = 1'b1; spi_rx = rxv(cur); sbusy = 0;
               end
            end
         end
      end
   end

   task automatic push(input logic [7:0] b);
      wb_cyc = 1'b1; wb_stb = 1'b1; wb_dat = b;
      while (wb_stall) @(negedge clk);
      @(negedge clk);
      chk(wb_ack, "R1", int'(wb_ack), 1);
      wb_stb = 1'b0; wb_cyc = 1'b0;
   endtask

   task automatic wait_quiet();
      int q = 0;
      while (q < 30) begin
         @(negedge clk);
         if (spi_cs_n && !spi_go) q++; else q = 0;
      end
   endtask

   task automatic clear();
      got_tx.delete(); got_res.delete(); exp_tx.delete(); exp_res.delete();
      err_seen = 0; cs_falls = 0;
   endtask

   task automatic compare(input string req, input int exp_err);
      chk(got_tx.size() == exp_tx.size(), req, got_tx.size(), exp_tx.size());
      for (int i = 0; i < exp_tx.size() && i < got_tx.size(); i++)
         chk(got_tx[i] == exp_tx[i], req, got_tx[i], exp_tx[i]);
      chk(got_res.size() == exp_res.size(), req, got_res.size(), exp_res.size());
      for (int i = 0; i < exp_res.size() && i < got_res.size(); i++)
         chk(got_res[i] == exp_res[i], req, got_res[i], exp_res[i]);
      chk(err_seen == exp_err, "R8", err_seen, exp_err);
   endtask

   task automatic exp_single(input logic [7:0] op);
      exp_tx.push_back(op);
   endtask
   task automatic exp_rreg(input logic [7:0] op, input logic [7:0] n);
      exp_tx.push_back(op); exp_tx.push_back(n);
      for (int i = 0; i <= int'(n); i++) begin
         exp_tx.push_back(8'h00); exp_res.push_back(rxv(i + 2));
      end
   endtask
   task automatic exp_stream(input int k);
      exp_tx.push_back(8'h10);
      for (int i = 0; i < k * FB; i++) begin
         exp_tx.push_back(8'h00); exp_res.push_back(rxv(i + 1));
      end
   endtask

   task automatic do_single(input logic [7:0] op);
      clear(); push(op); exp_single(op); wait_quiet(); compare("R2", 0);
   endtask
   task automatic do_rreg(input logic [7:0] op, input logic [7:0] n);
      clear(); push(op); push(n); exp_rreg(op, n); wait_quiet(); compare("R3", 0);
   endtask
   task automatic do_wreg(input logic [7:0] op, input logic [7:0] n);
      logic [7:0] d;
      clear(); push(op); push(n);
      exp_tx.push_back(op); exp_tx.push_back(n);
      for (int i = 0; i <= int'(n); i++) begin
         d = 8'($urandom); push(d); exp_tx.push_back(d);
      end
      wait_quiet(); compare("R4", 0);
   endtask
   task automatic do_stream(input int k);
      clear(); cur_stream = 1; push(8'h10); push(8'(k)); exp_stream(k);
      wait_quiet(); compare("R5", 0); cur_stream = 0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL R10: watchdog actual hung expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      int acc, n_res;
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      // R10 reset state
      chk(!wb_stall, "R10", int'(wb_stall), 0);
      chk(spi_cs_n, "R10", int'(spi_cs_n), 1);
      chk(!spi_go, "R10", int'(spi_go), 0);
      chk(!res_valid && !err, "R10", int'(res_valid | err), 0);
      rst_n = 1'b1;
      @(negedge clk);

      lat = 2; do_single(8'h04);
      do_rreg(8'h23, 8'd2);
      // R4: packet held until complete
      clear(); lat = 3;
      push(8'h45); push(8'd3); push(8'h11); push(8'h22); push(8'h33);
      repeat (10) @(negedge clk);
      chk(got_tx.size() == 0, "R4", got_tx.size(), 0);
      push(8'h44);
      exp_tx = '{8'h45, 8'd3, 8'h11, 8'h22, 8'h33, 8'h44};
      wait_quiet(); compare("R4", 0);
      do_stream(2);
      // R8 unknown opcode then valid command
      clear(); push(8'h77); push(8'h02); exp_single(8'h02);
      wait_quiet(); compare("R8", 1);
      // R9 back-to-back packets
      clear(); push(8'h02); push(8'h06); exp_single(8'h02); exp_single(8'h06);
      wait_quiet(); compare("R9", 0);
      chk(cs_falls == 2, "R9", cs_falls, 2);
      // R6 unlimited stream ended by stop
      clear(); cur_stream = 1; lat = 1;
      push(8'h10); push(8'h00);
      while (got_res.size() < 10) @(negedge clk);
      push(8'h11);
      wait_quiet(); cur_stream = 0;
      n_res = got_res.size();
      chk(n_res > 10 && n_res % FB == 0, "R6", n_res, ((n_res + FB - 1) / FB) * FB);
      chk(got_tx.size() == n_res + 1, "R6", got_tx.size(), n_res + 1);
      for (int i = 0; i < n_res; i++) chk(got_res[i] == rxv(i + 1), "R6", got_res[i], rxv(i + 1));
      chk(err_seen == 0, "R6", err_seen, 0);
      do_single(8'h02);

      // random mix
      for (int it = 0; it < 30; it++) begin
         int sel;
         lat = 1 + int'($urandom % 4);
         sel = int'($urandom % 5);
         case (sel)
            0: begin
               logic [7:0] ops [4];
               ops = '{8'h02, 8'h04, 8'h06, 8'h11};
               do_single(ops[$urandom % 4]);
            end
            1: do_rreg(8'h20 | 8'($urandom % 32), 8'($urandom % 4));
            2: do_wreg(8'h40 | 8'($urandom % 32), 8'($urandom % 4));
            3: do_stream(1 + int'($urandom % 3));
            default: begin
               clear(); push(8'h80 | 8'($urandom)); push(8'h04); exp_single(8'h04);
               wait_quiet(); compare("R8", 1);
            end
         endcase
      end

      // R1 FIFO fills to DEPTH during a stream
      clear(); lat = 6; cur_stream = 1;
      push(8'h10); push(8'd3);
      while (spi_cs_n || wb_stall) @(negedge clk);
      chk_stall = 0; acc = 0;
      wb_cyc = 1'b1; wb_dat = 8'h02;
      while (!wb_stall) begin
         wb_stb = 1'b1; acc++;
         @(negedge clk);
      end
      wb_stb = 1'b0; wb_cyc = 1'b0;
      chk(acc == DEPTH, "R1", acc, DEPTH);
      exp_stream(3);
      for (int i = 0; i < DEPTH; i++) exp_single(8'h02);
      wait_quiet(); compare("R5", 0);
      chk_stall = 1; cur_stream = 0;

      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule